// File: doc/BRIEF.md
# Serial Display Command Decoder

This block sits behind the byte output of a serial slave port in a grey-scale display controller. A separate select input decides what each incoming byte means. With select low the byte belongs to a command: an opcode followed by as many parameter bytes as that opcode takes. With select high the byte is pixel data. Each data byte holds two 4-bit grey pixels and is written into an internal frame memory at the current row and column.

Three commands change the decoder's state. One sets the column window, one sets the row window, and one sets a remap register. The remap register chooses whether the write pointer walks along rows or down columns. Commands that control analog behaviour still consume their parameter bytes, but they have no effect. After each data write the pointer advances and wraps inside the programmed rectangle.

Downstream scan-out logic reads the frame memory through a separate read port. It watches a one-cycle change pulse to learn when the picture has been altered.

Top module: `oled_cmd_decoder`

## Requirements
- R1: After reset the column window is 0..63, the row window is 0..79, the pointer is at row 0 column 0, vertical stepping is off, and no command is in progress. The first two data bytes therefore land at addresses 0 and 1, even if reset arrived part way through a command.
- R2: A byte taken with `byteValid` high and `dataSel` high is stored at address row*64 + column. That address presented on `rdAddr` appears on `rdData` one clock later.
- R3: Opcode 0x15 takes two parameters, the column start and the column end, each reduced modulo 64. The current column is set to the start value.
- R4: Opcode 0x75 takes two parameters, the row start and the row end, each reduced modulo 80. The current row is set to the start value.
- R5: With remap bit 2 clear, the column steps after each data byte. Past the column end, the column returns to the column start and the row steps. Past the row end, the row returns to the row start.
- R6: Opcode 0xA0 stores its single parameter as the remap register. With bit 2 of that register set, the row steps after each data byte. Past the row end, the row returns to the row start and the column steps. Past the column end, the column returns to the column start.
- R7: Parameter counts per opcode are fixed. 0xB8 takes eight. 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF take one. 0x84-0x86, 0xA4-0xA7, 0xAE, 0xAF and 0xE3 take none. None of these opcodes changes the windows or the pointer.
- R8: Opcode 0xFF and any opcode not listed above end the command after their own byte. The next command byte is read as a new opcode.
- R9: `frameDirty` is high for exactly one cycle after each accepted data byte, and is low at all other times.
- R10: A byte presented while `byteValid` is low changes nothing: no memory write, no pointer step, no dirty pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is presented this cycle |
| byteIn | input | 8 | Received byte |
| dataSel | input | 1 | 0 = command/parameter byte, 1 = pixel data byte |
| rdAddr | input | 13 | Frame memory read address (row*64 + column) |
| rdData | output | 8 | Frame memory read data, one cycle after rdAddr |
| frameDirty | output | 1 | One-cycle pulse after each data write |

## Verification
The write path is driven with several kinds of window. The reset default shows the initial pointer. A small horizontal rectangle shows column wrap into the next row and row wrap back to the start. A window set with out-of-range parameters shows the modulo reduction. A vertical two-by-two rectangle shows column-major stepping. A window on the last row and last columns covers the top of the address space. Every written byte is read back from its expected address, so an error in the stepping order, the window edges or the address arithmetic shows up as a wrong value. Directed sequences follow with long, zero-parameter, terminator and unknown opcodes. A misjudged parameter count shifts every later command byte, so the next data byte then lands in the wrong place.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;

  // Control-to-datapath strobes for one accepted byte.
  typedef struct packed {
    logic       wrData;    // pixel byte to store
    logic       setCol;    // column window command completed
    logic       setRow;    // row window command completed
    logic       setRemap;  // remap command completed
    logic [7:0] argA;      // first operand (start / remap / pixel)
    logic [7:0] argB;      // second operand (end)
  } strobe_t;

  localparam int MaxParams = 8;
  localparam int CntW      = $clog2(MaxParams + 1);

  localparam logic [7:0] OpSetCol   = 8'h15;
  localparam logic [7:0] OpSetRow   = 8'h75;
  localparam logic [7:0] OpSetRemap = 8'hA0;

  // Number of parameter bytes that follow an opcode.
  function automatic logic [CntW-1:0] paramCount(input logic [7:0] op);
    case (op)
      OpSetCol, OpSetRow:                       paramCount = CntW'(2);
      OpSetRemap, 8'h81, 8'hA1, 8'hA2, 8'hA8,
      8'hAD, 8'hB1, 8'hB2, 8'hB3, 8'hBC,
      8'hBE, 8'hBF:                             paramCount = CntW'(1);
      8'hB8:                                    paramCount = CntW'(MaxParams);
      default:                                  paramCount = '0;
    endcase
  endfunction

endpackage

// File: rtl/oled_cmd_ctrl.sv
module oled_cmd_ctrl
  import oled_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       dataSel,
  output strobe_t    strobe
);

  logic [CntW-1:0] idx;        // 0 = expecting opcode, k = expecting parameter k
  logic [CntW-1:0] need;       // parameter count of the open opcode
  logic [7:0]      opcode;
  logic [7:0]      firstParam;

  logic cmdByte, lastParam;
  assign cmdByte   = byteValid && !dataSel;
  assign lastParam = cmdByte && (idx != '0) && (idx == need);

  always_comb begin
    strobe = '0;
    if (byteValid && dataSel) begin
      strobe.wrData = 1'b1;
      strobe.argA   = byteIn;
    end else if (lastParam) begin
      case (opcode)
        OpSetCol: begin
          strobe.setCol = 1'b1;
          strobe.argA   = firstParam;
          strobe.argB   = byteIn;
        end
        OpSetRow: begin
          strobe.setRow = 1'b1;
          strobe.argA   = firstParam;
          strobe.argB   = byteIn;
        end
        OpSetRemap: begin
          strobe.setRemap = 1'b1;
          strobe.argA     = byteIn;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      need       <= '0;
      opcode     <= '0;
      firstParam <= '0;
    end else if (cmdByte) begin
      if (idx == '0) begin
        opcode <= byteIn;
        need   <= paramCount(byteIn);
        idx    <= (paramCount(byteIn) != '0) ? CntW'(1) : '0;
      end else begin
        if (idx == CntW'(1)) firstParam <= byteIn;
        idx <= lastParam ? '0 : idx + CntW'(1);
      end
    end
  end

  // R2: pixel bytes never disturb a command in progress.
  assert_data_keeps_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byteValid && dataSel) |=> $stable(idx));

  // R7: the parameter index never runs past the longest command.
  assert_idx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= CntW'(MaxParams));

  // R8: a terminator opcode leaves the sequencer idle.
  assert_term_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdByte && idx == '0 && byteIn == 8'hFF) |=> (idx == '0));

endmodule

// File: rtl/oled_frame_mem.sv
module oled_frame_mem #(
  parameter int DEPTH = 5120,
  parameter int AW    = 13
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [7:0]    wData,
  input  logic [AW-1:0] rAddr,
  output logic [7:0]    rData
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
    rData <= mem[rAddr];
  end

endmodule

// File: rtl/oled_addr_path.sv
module oled_addr_path
  import oled_dec_pkg::*;
#(
  parameter int COLS    = 64,
  parameter int ROWS    = 80,
  parameter int VERTBIT = 2,
  localparam int CW     = $clog2(COLS),
  localparam int RW     = $clog2(ROWS),
  localparam int AW     = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       strobe,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          frameDirty
);

  logic [CW-1:0] col, colStart, colEnd;
  logic [RW-1:0] row, rowStart, rowEnd;
  logic [7:0]    remap;
  logic          vertical;
  assign vertical = remap[VERTBIT];

  logic [CW-1:0] argColA, argColB;
  logic [RW-1:0] argRowA, argRowB;
  assign argColA = CW'(32'(strobe.argA) % COLS);
  assign argColB = CW'(32'(strobe.argB) % COLS);
  assign argRowA = RW'(32'(strobe.argA) % ROWS);
  assign argRowB = RW'(32'(strobe.argB) % ROWS);

  logic [AW-1:0] wrAddr;
  assign wrAddr = AW'(32'(row) * COLS + 32'(col));

  // Pointer step inside the window.
  logic [CW:0]   colInc, colTmp;
  logic [RW:0]   rowInc, rowTmp;
  logic [CW-1:0] nextCol;
  logic [RW-1:0] nextRow;

  always_comb begin
    colInc = {1'b0, col} + 1'b1;
    rowInc = {1'b0, row} + 1'b1;
    if (vertical) begin
      if (rowInc > {1'b0, rowEnd}) begin
        nextRow = rowStart;
        colTmp  = colInc;
      end else begin
        nextRow = rowInc[RW-1:0];
        colTmp  = {1'b0, col};
      end
      nextCol = (colTmp > {1'b0, colEnd}) ? colStart : colTmp[CW-1:0];
      rowTmp  = '0;
    end else begin
      if (colInc > {1'b0, colEnd}) begin
        nextCol = colStart;
        rowTmp  = rowInc;
      end else begin
        nextCol = colInc[CW-1:0];
        rowTmp  = {1'b0, row};
      end
      nextRow = (rowTmp > {1'b0, rowEnd}) ? rowStart : rowTmp[RW-1:0];
      colTmp  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col        <= '0;
      colStart   <= '0;
      colEnd     <= CW'(COLS - 1);
      row        <= '0;
      rowStart   <= '0;
      rowEnd     <= RW'(ROWS - 1);
      remap      <= '0;
      frameDirty <= 1'b0;
    end else begin
      frameDirty <= strobe.wrData;
      if (strobe.wrData) begin
        col <= nextCol;
        row <= nextRow;
      end
      if (strobe.setCol) begin
        col      <= argColA;
        colStart <= argColA;
        colEnd   <= argColB;
      end
      if (strobe.setRow) begin
        row      <= argRowA;
        rowStart <= argRowA;
        rowEnd   <= argRowB;
      end
      if (strobe.setRemap) remap <= strobe.argA;
    end
  end

  oled_frame_mem #(.DEPTH(COLS * ROWS), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (strobe.wrData),
    .wAddr (wrAddr),
    .wData (strobe.argA),
    .rAddr (rdAddr),
    .rData (rdData)
  );

  // R3: a column command parks the pointer on the new start.
  assert_col_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.setCol |=> (col == colStart));

  // R4: the row pointer stays inside the array.
  assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, row} < (RW+1)'(ROWS)));

  // R5: pixel writes leave the window untouched.
  assert_window_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrData |=> ($stable(colStart) && $stable(colEnd) &&
                       $stable(rowStart) && $stable(rowEnd)));

  // R5: horizontal stepping keeps the row until the column end.
  assert_horiz_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrData && !vertical && col < colEnd) |=> $stable(row));

  // R6: vertical stepping keeps the column until the row end.
  assert_vert_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrData && vertical && row < rowEnd) |=> $stable(col));

endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
  import oled_dec_pkg::*;
#(
  parameter int COLS = 64,
  parameter int ROWS = 80,
  localparam int AW  = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byteValid,
  input  logic [7:0]    byteIn,
  input  logic          dataSel,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          frameDirty
);

  strobe_t strobe;

  oled_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .byteValid (byteValid),
    .byteIn    (byteIn),
    .dataSel   (dataSel),
    .strobe    (strobe)
  );

  oled_addr_path #(.COLS(COLS), .ROWS(ROWS)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .frameDirty (frameDirty)
  );

  // R9, R10: a dirty pulse only follows an accepted data byte.
  assert_dirty_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frameDirty |-> $past(byteValid && dataSel));

endmodule

// File: tb/oled_cmd_decoder_bench.sv
module oled_cmd_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        dataSel = 1'b0;
  logic [12:0] rdAddr = '0;
  logic [7:0]  rdData;
  logic        frameDirty;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  oled_cmd_decoder u_oled_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteIn(byteIn),
    .dataSel(dataSel), .rdAddr(rdAddr), .rdData(rdData), .frameDirty(frameDirty)
  );

  // {isData, tag, byte, expected address}
  localparam int NV = 58;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1,4'd1,8'hA1,13'd0},    {1'b1,4'd1,8'hA2,13'd1},
    {1'b0,4'd0,8'h15,13'd0},    {1'b0,4'd0,8'h03,13'd0},   {1'b0,4'd0,8'h05,13'd0},
    {1'b0,4'd0,8'h75,13'd0},    {1'b0,4'd0,8'h02,13'd0},   {1'b0,4'd0,8'h03,13'd0},
    {1'b1,4'd5,8'h10,13'd131},  {1'b1,4'd5,8'h11,13'd132}, {1'b1,4'd5,8'h12,13'd133},
    {1'b1,4'd5,8'h13,13'd195},  {1'b1,4'd5,8'h14,13'd196}, {1'b1,4'd5,8'h15,13'd197},
    {1'b1,4'd5,8'h16,13'd131},
    {1'b0,4'd0,8'h15,13'd0},    {1'b0,4'd0,8'h45,13'd0},   {1'b0,4'd0,8'h46,13'd0},
    {1'b0,4'd0,8'h75,13'd0},    {1'b0,4'd0,8'h52,13'd0},   {1'b0,4'd0,8'h53,13'd0},
    {1'b1,4'd3,8'h20,13'd133},  {1'b1,4'd3,8'h21,13'd134},
    {1'b1,4'd4,8'h22,13'd197},  {1'b1,4'd4,8'h23,13'd198},
    {1'b0,4'd0,8'hFF,13'd0},    {1'b0,4'd0,8'h00,13'd0},
    {1'b0,4'd0,8'h15,13'd0},    {1'b0,4'd0,8'h14,13'd0},   {1'b0,4'd0,8'h14,13'd0},
    {1'b0,4'd0,8'h75,13'd0},    {1'b0,4'd0,8'h14,13'd0},   {1'b0,4'd0,8'h14,13'd0},
    {1'b1,4'd8,8'h31,13'd1300},
    {1'b0,4'd0,8'hA0,13'd0},    {1'b0,4'd0,8'h04,13'd0},
    {1'b0,4'd0,8'h15,13'd0},    {1'b0,4'd0,8'h1E,13'd0},   {1'b0,4'd0,8'h1F,13'd0},
    {1'b0,4'd0,8'h75,13'd0},    {1'b0,4'd0,8'h28,13'd0},   {1'b0,4'd0,8'h29,13'd0},
    {1'b1,4'd6,8'h40,13'd2590}, {1'b1,4'd6,8'h41,13'd2654}, {1'b1,4'd6,8'h42,13'd2591},
    {1'b1,4'd6,8'h43,13'd2655}, {1'b1,4'd6,8'h44,13'd2590},
    {1'b0,4'd0,8'hA0,13'd0},    {1'b0,4'd0,8'h00,13'd0},
    {1'b0,4'd0,8'h15,13'd0},    {1'b0,4'd0,8'h3E,13'd0},   {1'b0,4'd0,8'h3F,13'd0},
    {1'b0,4'd0,8'h75,13'd0},    {1'b0,4'd0,8'h4F,13'd0},   {1'b0,4'd0,8'h4F,13'd0},
    {1'b1,4'd5,8'h50,13'd5118}, {1'b1,4'd5,8'h51,13'd5119}, {1'b1,4'd5,8'h52,13'd5118}
  };

  function automatic string reqName(input logic [3:0] t);
    case (t)
      4'd1: reqName = "R1";
      4'd3: reqName = "R3";
      4'd4: reqName = "R4";
      4'd5: reqName = "R5";
      4'd6: reqName = "R6";
      4'd8: reqName = "R8";
      default: reqName = "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; the byte is taken at the following rising edge.
  task automatic sendByte(input logic dc, input logic [7:0] b);
    @(negedge clk);
    byteValid = 1'b1;
    dataSel   = dc;
    byteIn    = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic readCheck(input logic [12:0] a, input logic [7:0] exp, input string req);
    rdAddr = a;
    @(negedge clk);
    check(rdData == exp, req, rdData, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    byteValid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    check(frameDirty == 1'b0, "R1", frameDirty, 0);

    // Table walk: R2 plus window behaviour per tag.
    for (int i = 0; i < NV; i++) begin
      sendByte(VEC[i][25], VEC[i][20:13]);
      if (VEC[i][25]) readCheck(VEC[i][12:0], VEC[i][20:13], reqName(VEC[i][24:21]));
    end

    // R7: long, one- and zero-parameter opcodes must not swallow later commands.
    sendByte(1'b0, 8'hB8);
    for (int k = 0; k < 8; k++) sendByte(1'b0, 8'h75);
    sendByte(1'b0, 8'h81); sendByte(1'b0, 8'h15);
    sendByte(1'b0, 8'hA4); sendByte(1'b0, 8'h85); sendByte(1'b0, 8'hE3);
    sendByte(1'b0, 8'h15); sendByte(1'b0, 8'h0A); sendByte(1'b0, 8'h0A);
    sendByte(1'b0, 8'h75); sendByte(1'b0, 8'h0A); sendByte(1'b0, 8'h0A);
    sendByte(1'b1, 8'h61);
    readCheck(13'd650, 8'h61, "R7");
    sendByte(1'b0, 8'hBF); sendByte(1'b0, 8'h15);
    sendByte(1'b1, 8'h62);
    readCheck(13'd650, 8'h62, "R7");

    // R9: pulse one cycle after the accepted byte, then low.
    @(negedge clk);
    byteValid = 1'b1; dataSel = 1'b1; byteIn = 8'h63;
    @(negedge clk);
    byteValid = 1'b0;
    check(frameDirty == 1'b1, "R9", frameDirty, 1);
    @(negedge clk);
    check(frameDirty == 1'b0, "R9", frameDirty, 0);

    // R10: a byte without valid changes nothing.
    @(negedge clk);
    byteValid = 1'b0; dataSel = 1'b1; byteIn = 8'h99;
    @(negedge clk);
    check(frameDirty == 1'b0, "R10", frameDirty, 0);
    readCheck(13'd650, 8'h63, "R10");
    sendByte(1'b1, 8'h64);
    readCheck(13'd650, 8'h64, "R10");

    // R1: reset part way through a command restores defaults.
    sendByte(1'b0, 8'h15); sendByte(1'b0, 8'h05);
    doReset();
    sendByte(1'b1, 8'h70);
    readCheck(13'd0, 8'h70, "R1");
    sendByte(1'b1, 8'h71);
    readCheck(13'd1, 8'h71, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule